// File: doc/BRIEF.md
# Chunked Memory Copy Command Generator

This block converts one copy request into the ordered list of 32-bit command words that a memory-to-memory copy engine consumes. Each word is a (method, data) pair on a valid/ready stream. A request describes either a rectangle in two pitched linear surfaces or a flat byte range. For a rectangle it gives a base offset, pitch and origin for each side, plus a width in pixels, a height in lines and a pixel size in bytes. For a flat range it gives a byte count.

The engine copies at most a fixed number of lines per command group. The block therefore cuts the work into chunks. It recomputes the source and destination offsets for every chunk, and it closes every chunk with two flush words that the engine requires. For a flat range, the work is split into whole pages copied as lines, plus one short line for any remainder. When the last word of a request has been accepted, the block raises a one-cycle completion pulse and returns to idle.

Top module: `mcopy_cmdgen`

## Requirements
- R1: In rectangle mode (`req_buf_mode`=0), the first chunk's source offset word is src_base + src_y·src_pitch + src_x·bpp, and its destination offset word is dst_base + dst_y·dst_pitch + dst_x·bpp. Both are taken modulo 2^32.
- R2: After a request is accepted, the first two words are a header: method 0x1 carrying the source domain bit, then method 0x2 carrying the destination domain bit. The header appears once per request, before any chunk.
- R3: Every chunk starts with eight words in this order: 0x3 source offset, 0x4 destination offset, 0x5 source pitch, 0x6 destination pitch, 0x7 line length in bytes (width·bpp in rectangle mode), 0x8 line count, 0x9 format word 0x00000101 (input and output step of one), and 0xA with data 0.
- R4: Each chunk's eight words are followed by method 0xB (no-operation) with data 0, then method 0xC (output-offset flush) with data 0.
- R5: A chunk's line count is the smaller of the lines remaining and MAX_LINES (default 2047). It is never zero.
- R6: After a chunk, the source offset advances by source pitch times the chunk's line count, and the destination offset advances by destination pitch times the chunk's line count.
- R7: In buffer mode (`req_buf_mode`=1), the offsets start at the bases. Whole 4096-byte pages are sent as lines with both pitches and the line length set to 4096, in chunks that follow R5 and R6.
- R8: In buffer mode, a nonzero remainder below 4096 bytes is sent last, as one chunk of one line whose pitches and line length all equal the remainder.
- R9: A rectangle of zero lines, or a buffer of zero bytes, produces only the two header words and then the completion pulse.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the presented method and data stay unchanged and no word is lost.
- R11: `done` is high for exactly one cycle after the last word is accepted. `req_ready` is high only when idle, and a request offered while busy is ignored.
- R12: During reset, `cmd_valid`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_buf_mode | input | 1 | 1 selects flat byte-range mode |
| req_src_dom | input | 1 | Source memory domain bit |
| req_dst_dom | input | 1 | Destination memory domain bit |
| req_src_base | input | AW | Source base offset |
| req_dst_base | input | AW | Destination base offset |
| req_src_pitch | input | PW | Source bytes per line |
| req_dst_pitch | input | PW | Destination bytes per line |
| req_src_x | input | CW | Source pixel column |
| req_src_y | input | CW | Source line |
| req_dst_x | input | CW | Destination pixel column |
| req_dst_y | input | CW | Destination line |
| req_width | input | CW | Rectangle width in pixels |
| req_height | input | LW | Rectangle height in lines |
| req_bpp | input | BW | Bytes per pixel |
| req_size | input | AW | Byte count in buffer mode |
| cmd_valid | output | 1 | Command word present |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_method | output | 4 | Method code of the word |
| cmd_data | output | DW | Data of the word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same cycle: a consumer stall, and the chunk boundary at which the flush word is accepted and both offsets and the line counter are advanced. Back-pressure from a pseudo-random ready pattern is applied across requests of 2047, 2048 and 4100 lines, and across page-plus-remainder buffers, so that stalls fall on and next to those boundaries. Each captured word stream is then compared, word by word, with an independently computed list of expected words. A separate long stall holds ready low mid-header while a second request is offered, to show that the held word and the sequence are unaffected.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_CHUNK, ST_FIN} seq_state_e;

    localparam int MW = 4;
    localparam logic [MW-1:0] M_SRC_DOM   = 4'h1;
    localparam logic [MW-1:0] M_DST_DOM   = 4'h2;
    localparam logic [MW-1:0] M_SRC_OFS   = 4'h3;
    localparam logic [MW-1:0] M_DST_OFS   = 4'h4;
    localparam logic [MW-1:0] M_SRC_PITCH = 4'h5;
    localparam logic [MW-1:0] M_DST_PITCH = 4'h6;
    localparam logic [MW-1:0] M_LINE_LEN  = 4'h7;
    localparam logic [MW-1:0] M_LINE_CNT  = 4'h8;
    localparam logic [MW-1:0] M_FORMAT    = 4'h9;
    localparam logic [MW-1:0] M_LAUNCH    = 4'hA;
    localparam logic [MW-1:0] M_NOP       = 4'hB;
    localparam logic [MW-1:0] M_FLUSH     = 4'hC;

    localparam logic [31:0] FMT_STEP_ONE = 32'h0000_0101;
    localparam int IDX_W       = 4;
    localparam int HDR_WORDS   = 2;
    localparam int CHUNK_WORDS = 10;
endpackage

// File: rtl/mcg_start_offset.sv
module mcg_start_offset #(
    parameter int AW = 32,
    parameter int PW = 16,
    parameter int CW = 16,
    parameter int BW = 3
) (
    input  logic [AW-1:0] base,
    input  logic [PW-1:0] pitch,
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    input  logic [BW-1:0] bpp,
    output logic [AW-1:0] ofs
);
    logic [AW-1:0] row_term;
    logic [AW-1:0] col_term;

    always_comb begin
        row_term = AW'(row) * AW'(pitch);
        col_term = AW'(col) * AW'(bpp);
        ofs      = base + row_term + col_term;
    end
endmodule

// File: rtl/mcg_chunk_size.sv
module mcg_chunk_size #(
    parameter int RW        = 32,
    parameter int MAX_LINES = 2047
) (
    input  logic [RW-1:0] remain,
    output logic [RW-1:0] lines,
    output logic          last_chunk
);
    localparam logic [RW-1:0] CAP = RW'(MAX_LINES);

    always_comb begin
        last_chunk = (remain <= CAP);
        lines      = last_chunk ? remain : CAP;
    end
endmodule

// File: rtl/mcg_word_sel.sv
module mcg_word_sel
    import mcg_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  seq_state_e        st,
    input  logic [IDX_W-1:0]  idx,
    input  logic              src_dom,
    input  logic              dst_dom,
    input  logic [AW-1:0]     src_ofs,
    input  logic [AW-1:0]     dst_ofs,
    input  logic [DW-1:0]     src_pitch,
    input  logic [DW-1:0]     dst_pitch,
    input  logic [DW-1:0]     line_len,
    input  logic [AW-1:0]     lines,
    output logic [MW-1:0]     method,
    output logic [DW-1:0]     data
);
    always_comb begin
        method = '0;
        data   = '0;
        if (st == ST_HDR) begin
            if (idx == '0) begin
                method = M_SRC_DOM;
                data   = DW'(src_dom);
            end else begin
                method = M_DST_DOM;
                data   = DW'(dst_dom);
            end
        end else if (st == ST_CHUNK) begin
            case (idx)
                4'd0: begin method = M_SRC_OFS;   data = DW'(src_ofs); end
                4'd1: begin method = M_DST_OFS;   data = DW'(dst_ofs); end
                4'd2: begin method = M_SRC_PITCH; data = src_pitch;    end
                4'd3: begin method = M_DST_PITCH; data = dst_pitch;    end
                4'd4: begin method = M_LINE_LEN;  data = line_len;     end
                4'd5: begin method = M_LINE_CNT;  data = DW'(lines);   end
                4'd6: begin method = M_FORMAT;    data = DW'(FMT_STEP_ONE); end
                4'd7: begin method = M_LAUNCH;    data = '0;           end
                4'd8: begin method = M_NOP;       data = '0;           end
                default: begin method = M_FLUSH;  data = '0;           end
            endcase
        end
    end
endmodule

// File: rtl/mcopy_cmdgen.sv
module mcopy_cmdgen
    import mcg_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int PW        = 16,
    parameter int CW        = 16,
    parameter int LW        = 16,
    parameter int BW        = 3,
    parameter int MAX_LINES = 2047,
    parameter int PAGE_LG   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_buf_mode,
    input  logic          req_src_dom,
    input  logic          req_dst_dom,
    input  logic [AW-1:0] req_src_base,
    input  logic [AW-1:0] req_dst_base,
    input  logic [PW-1:0] req_src_pitch,
    input  logic [PW-1:0] req_dst_pitch,
    input  logic [CW-1:0] req_src_x,
    input  logic [CW-1:0] req_src_y,
    input  logic [CW-1:0] req_dst_x,
    input  logic [CW-1:0] req_dst_y,
    input  logic [CW-1:0] req_width,
    input  logic [LW-1:0] req_height,
    input  logic [BW-1:0] req_bpp,
    input  logic [AW-1:0] req_size,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [3:0]    cmd_method,
    output logic [DW-1:0] cmd_data,
    output logic          done
);
    localparam int RW         = AW;
    localparam int PAGE_BYTES = 1 << PAGE_LG;
    localparam logic [IDX_W-1:0] HDR_LAST   = IDX_W'(HDR_WORDS - 1);
    localparam logic [IDX_W-1:0] CHUNK_LAST = IDX_W'(CHUNK_WORDS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic               src_dom;
        logic               dst_dom;
        logic [AW-1:0]      src_ofs;
        logic [AW-1:0]      dst_ofs;
        logic [DW-1:0]      src_pitch;
        logic [DW-1:0]      dst_pitch;
        logic [DW-1:0]      line_len;
        logic [RW-1:0]      remain;
        logic [PAGE_LG-1:0] tail;
    } seq_t;

    seq_t q, d;

    // start offsets for both sides, same structure twice
    logic [AW-1:0] side_base  [2];
    logic [PW-1:0] side_pitch [2];
    logic [CW-1:0] side_col   [2];
    logic [CW-1:0] side_row   [2];
    logic [AW-1:0] side_start [2];

    assign side_base[0]  = req_src_base;
    assign side_base[1]  = req_dst_base;
    assign side_pitch[0] = req_src_pitch;
    assign side_pitch[1] = req_dst_pitch;
    assign side_col[0]   = req_src_x;
    assign side_col[1]   = req_dst_x;
    assign side_row[0]   = req_src_y;
    assign side_row[1]   = req_dst_y;

    for (genvar s = 0; s < 2; s++) begin : g_side
        mcg_start_offset #(.AW(AW), .PW(PW), .CW(CW), .BW(BW)) u_start (
            .base  (side_base[s]),
            .pitch (side_pitch[s]),
            .col   (side_col[s]),
            .row   (side_row[s]),
            .bpp   (req_bpp),
            .ofs   (side_start[s])
        );
    end

    logic [RW-1:0] chunk_lines;
    logic          chunk_final;

    mcg_chunk_size #(.RW(RW), .MAX_LINES(MAX_LINES)) u_size (
        .remain     (q.remain),
        .lines      (chunk_lines),
        .last_chunk (chunk_final)
    );

    mcg_word_sel #(.AW(AW), .DW(DW)) u_sel (
        .st        (q.st),
        .idx       (q.idx),
        .src_dom   (q.src_dom),
        .dst_dom   (q.dst_dom),
        .src_ofs   (q.src_ofs),
        .dst_ofs   (q.dst_ofs),
        .src_pitch (q.src_pitch),
        .dst_pitch (q.dst_pitch),
        .line_len  (q.line_len),
        .lines     (chunk_lines),
        .method    (cmd_method),
        .data      (cmd_data)
    );

    assign cmd_valid = (q.st == ST_HDR) || (q.st == ST_CHUNK);
    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_FIN);

    logic          fire;
    logic          seek;
    logic [RW-1:0] seek_rem;
    logic [RW-1:0] rem_after;

    always_comb begin
        d         = q;
        fire      = cmd_valid && cmd_ready;
        seek      = 1'b0;
        seek_rem  = q.remain;
        rem_after = chunk_final ? '0 : (q.remain - chunk_lines);
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st      = ST_HDR;
                    d.idx     = '0;
                    d.src_dom = req_src_dom;
                    d.dst_dom = req_dst_dom;
                    if (req_buf_mode) begin
                        d.src_ofs   = req_src_base;
                        d.dst_ofs   = req_dst_base;
                        d.src_pitch = DW'(PAGE_BYTES);
                        d.dst_pitch = DW'(PAGE_BYTES);
                        d.line_len  = DW'(PAGE_BYTES);
                        d.remain    = RW'(req_size >> PAGE_LG);
                        d.tail      = req_size[PAGE_LG-1:0];
                    end else begin
                        d.src_ofs   = side_start[0];
                        d.dst_ofs   = side_start[1];
                        d.src_pitch = DW'(req_src_pitch);
                        d.dst_pitch = DW'(req_dst_pitch);
                        d.line_len  = DW'(req_width) * DW'(req_bpp);
                        d.remain    = RW'(req_height);
                        d.tail      = '0;
                    end
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (q.idx == HDR_LAST) begin
                        seek     = 1'b1;
                        seek_rem = q.remain;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_CHUNK: begin
                if (fire) begin
                    if (q.idx == CHUNK_LAST) begin
                        d.src_ofs = q.src_ofs + AW'(AW'(q.src_pitch) * chunk_lines);
                        d.dst_ofs = q.dst_ofs + AW'(AW'(q.dst_pitch) * chunk_lines);
                        d.remain  = rem_after;
                        seek      = 1'b1;
                        seek_rem  = rem_after;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (seek) begin
            d.idx = '0;
            if (seek_rem != '0) begin
                d.st = ST_CHUNK;
            end else if (q.tail != '0) begin
                d.st        = ST_CHUNK;
                d.src_pitch = DW'(q.tail);
                d.dst_pitch = DW'(q.tail);
                d.line_len  = DW'(q.tail);
                d.remain    = RW'(1);
                d.tail      = '0;
            end else begin
                d.st = ST_FIN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: a stalled word is held unchanged
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_method) && $stable(cmd_data));

    // R11: completion is a single-cycle pulse followed by idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready && !cmd_valid);

    // R2: an accepted request opens with the source-domain header word
    a_r2_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> cmd_valid && cmd_method == M_SRC_DOM);

    // R5: line count word within 1..MAX_LINES
    a_r5_line_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_method == M_LINE_CNT |-> cmd_data != '0 && cmd_data <= DW'(MAX_LINES));

    // R4: the closing pair carries zero data
    a_r4_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_method == M_NOP || cmd_method == M_FLUSH) |-> cmd_data == '0);

    // R11: no word is presented while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid && !done);
endmodule

// File: tb/sim_mcopy_cmdgen.sv
module sim_mcopy_cmdgen;
    typedef struct packed {
        logic        bm;
        logic        sd;
        logic        dd;
        logic [31:0] sb;
        logic [31:0] db;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [15:0] sx;
        logic [15:0] sy;
        logic [15:0] dx;
        logic [15:0] dy;
        logic [15:0] w;
        logic [15:0] h;
        logic [2:0]  bpp;
        logic [31:0] sz;
        logic [7:0]  nw;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 1'b1, 1'b0, 32'h1000,   32'h8000,   16'd256, 16'd512, 16'd3, 16'd2, 16'd5, 16'd1, 16'd10, 16'd4,    3'd4, 32'd0,       8'd12},
        '{1'b0, 1'b0, 1'b1, 32'h20000,  32'h40000,  16'd64,  16'd128, 16'd0, 16'd7, 16'd1, 16'd0, 16'd16, 16'd2047, 3'd2, 32'd0,       8'd12},
        '{1'b0, 1'b1, 1'b1, 32'h0,      32'h100,    16'd32,  16'd48,  16'd1, 16'd0, 16'd2, 16'd3, 16'd8,  16'd2048, 3'd1, 32'd0,       8'd22},
        '{1'b0, 1'b0, 1'b0, 32'h500,    32'h900000, 16'd100, 16'd200, 16'd4, 16'd4, 16'd0, 16'd0, 16'd25, 16'd4100, 3'd4, 32'd0,       8'd32},
        '{1'b1, 1'b1, 1'b0, 32'h3000,   32'h9000,   16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd8292,    8'd22},
        '{1'b1, 1'b0, 1'b1, 32'h10,     32'h7000,   16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd8392704, 8'd22},
        '{1'b1, 1'b1, 1'b1, 32'h4,      32'h8,      16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd8388615, 8'd32},
        '{1'b1, 1'b0, 1'b0, 32'h600,    32'h700,    16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd50,      8'd12},
        '{1'b0, 1'b1, 1'b0, 32'h1000,   32'h2000,   16'd64,  16'd64,  16'd1, 16'd1, 16'd1, 16'd1, 16'd10, 16'd0,    3'd4, 32'd0,       8'd2},
        '{1'b1, 1'b0, 1'b1, 32'h1000,   32'h2000,   16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd0,       8'd2},
        '{1'b1, 1'b1, 1'b0, 32'hA000,   32'hB000,   16'd0,   16'd0,   16'd0, 16'd0, 16'd0, 16'd0, 16'd0,  16'd0,    3'd0, 32'd4096,    8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_buf_mode = 1'b0;
    logic        req_src_dom = 1'b0;
    logic        req_dst_dom = 1'b0;
    logic [31:0] req_src_base = '0;
    logic [31:0] req_dst_base = '0;
    logic [15:0] req_src_pitch = '0;
    logic [15:0] req_dst_pitch = '0;
    logic [15:0] req_src_x = '0;
    logic [15:0] req_src_y = '0;
    logic [15:0] req_dst_x = '0;
    logic [15:0] req_dst_y = '0;
    logic [15:0] req_width = '0;
    logic [15:0] req_height = '0;
    logic [2:0]  req_bpp = '0;
    logic [31:0] req_size = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_method;
    logic [31:0] cmd_data;
    logic        done;

    always #10 clk = ~clk;

    mcopy_cmdgen u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_buf_mode(req_buf_mode), .req_src_dom(req_src_dom), .req_dst_dom(req_dst_dom),
        .req_src_base(req_src_base), .req_dst_base(req_dst_base),
        .req_src_pitch(req_src_pitch), .req_dst_pitch(req_dst_pitch),
        .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
        .req_width(req_width), .req_height(req_height),
        .req_bpp(req_bpp), .req_size(req_size),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_method(cmd_method), .cmd_data(cmd_data), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [3:0]  exp_m [0:63];
    logic [31:0] exp_d [0:63];
    string       exp_t [0:63];
    int          n_exp;

    logic [3:0]  got_m [0:255];
    logic [31:0] got_d [0:255];
    int          n_got = 0;
    int          n_done = 0;
    int          stall_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] m, input logic [31:0] dv, input string t);
        exp_m[n_exp] = m;
        exp_d[n_exp] = dv;
        exp_t[n_exp] = t;
        n_exp++;
    endtask

    // expected word list built from the requirements
    task automatic model(input vec_t v);
        logic [31:0] so, dof, spv, dpv, len, rem, tl, n;
        bit first, in_tail;
        n_exp = 0;
        push(4'h1, {31'd0, v.sd}, "R2");
        push(4'h2, {31'd0, v.dd}, "R2");
        if (!v.bm) begin
            so  = v.sb + v.sy * v.sp + v.sx * v.bpp;
            dof = v.db + v.dy * v.dp + v.dx * v.bpp;
            spv = {16'd0, v.sp};
            dpv = {16'd0, v.dp};
            len = v.w * v.bpp;
            rem = {16'd0, v.h};
            tl  = 0;
        end else begin
            so  = v.sb;
            dof = v.db;
            spv = 4096;
            dpv = 4096;
            len = 4096;
            rem = v.sz / 4096;
            tl  = v.sz % 4096;
        end
        first   = 1;
        in_tail = 0;
        while (rem != 0 || tl != 0) begin
            if (rem == 0) begin
                spv = tl; dpv = tl; len = tl; rem = 1; tl = 0; in_tail = 1;
            end
            n = (rem > 2047) ? 2047 : rem;
            push(4'h3, so,  (first && !v.bm) ? "R1" : "R6");
            push(4'h4, dof, (first && !v.bm) ? "R1" : "R6");
            push(4'h5, spv, in_tail ? "R8" : (v.bm ? "R7" : "R3"));
            push(4'h6, dpv, in_tail ? "R8" : (v.bm ? "R7" : "R3"));
            push(4'h7, len, in_tail ? "R8" : (v.bm ? "R7" : "R3"));
            push(4'h8, n, "R5");
            push(4'h9, 32'h0000_0101, "R3");
            push(4'hA, 32'h0, "R3");
            push(4'hB, 32'h0, "R4");
            push(4'hC, 32'h0, "R4");
            so  = so + spv * n;
            dof = dof + dpv * n;
            rem = rem - n;
            first = 0;
        end
    endtask

    // ready driver and stream monitor
    initial begin
        forever begin
            @(negedge clk);
            case (stall_mode)
                0: cmd_ready = 1'b1;
                1: cmd_ready = lfsr[0] | lfsr[3];
                default: cmd_ready = 1'b0;
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (rst_n) begin
                if (cmd_valid && cmd_ready && n_got < 256) begin
                    got_m[n_got] = cmd_method;
                    got_d[n_got] = cmd_data;
                    n_got++;
                end
                if (done) n_done++;
            end
        end
    end

    task automatic drive(input vec_t v);
        req_buf_mode  = v.bm;
        req_src_dom   = v.sd;
        req_dst_dom   = v.dd;
        req_src_base  = v.sb;
        req_dst_base  = v.db;
        req_src_pitch = v.sp;
        req_dst_pitch = v.dp;
        req_src_x     = v.sx;
        req_src_y     = v.sy;
        req_dst_x     = v.dx;
        req_dst_y     = v.dy;
        req_width     = v.w;
        req_height    = v.h;
        req_bpp       = v.bpp;
        req_size      = v.sz;
    endtask

    task automatic finish_and_compare(input vec_t v, input int base_done);
        int t;
        t = 0;
        while (n_done == base_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(n_done == base_done + 1, "R11", "done seen", 64'(n_done - base_done), 64'd1);
        chk(n_got == n_exp, n_exp == 2 ? "R9" : "R5", "word count vs model", 64'(n_got), 64'(n_exp));
        chk(n_exp == int'(v.nw), "R3", "model count vs table", 64'(n_exp), 64'(v.nw));
        for (int k = 0; k < n_exp && k < n_got; k++) begin
            chk(got_m[k] == exp_m[k] && got_d[k] == exp_d[k], exp_t[k], $sformatf("word %0d", k),
                {28'd0, got_m[k], got_d[k]}, {28'd0, exp_m[k], exp_d[k]});
        end
        repeat (3) @(negedge clk);
        #2;
        chk(n_done == base_done + 1 && !cmd_valid && req_ready, "R11", "single pulse then idle",
            64'(n_done - base_done), 64'd1);
    endtask

    task automatic run_vec(input vec_t v);
        int base_done;
        model(v);
        @(negedge clk);
        n_got = 0;
        base_done = n_done;
        drive(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        finish_and_compare(v, base_done);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0]  hm;
        logic [31:0] hd;
        int          bd;
        repeat (3) @(negedge clk);
        #2;
        chk(cmd_valid == 1'b0, "R12", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
        chk(done == 1'b0, "R12", "done in reset", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R12", "req_ready in reset", 64'(req_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk, alternating free-flowing and random back-pressure
        for (int i = 0; i < NV; i++) begin
            stall_mode = i % 2;
            run_vec(VEC[i]);
        end
        for (int i = 0; i < NV; i++) begin
            stall_mode = (i + 1) % 2;
            run_vec(VEC[i]);
        end

        // directed: long stall in the header, busy request ignored (R10, R11)
        stall_mode = 2;
        model(VEC[0]);
        @(negedge clk);
        n_got = 0;
        bd = n_done;
        drive(VEC[0]);
        req_valid = 1'b1;
        @(negedge clk);
        drive(VEC[4]);
        repeat (2) @(negedge clk);
        #2;
        chk(cmd_valid && !req_ready, "R11", "busy while stalled", {62'd0, cmd_valid, req_ready}, 64'd2);
        hm = cmd_method;
        hd = cmd_data;
        repeat (5) @(negedge clk);
        #2;
        chk(cmd_valid && cmd_method == hm && cmd_data == hd, "R10", "held word",
            {28'd0, cmd_method, cmd_data}, {28'd0, hm, hd});
        chk(cmd_method == 4'h1, "R10", "held method", 64'(cmd_method), 64'd1);
        req_valid = 1'b0;
        stall_mode = 0;
        finish_and_compare(VEC[0], bd);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule